// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Command Sequencer

This block owns the command pins of a single-data-rate SDRAM from reset onward. Once reset is released it raises clock enable and holds NOP on the command pins for a power-up interval. It then precharges every bank and issues a fixed group of auto-refresh commands. Next it writes the mode register with a word packed from configuration inputs. After that it keeps the memory alive with periodic auto-refresh commands paced by a reloading interval counter.

The minimum spacing after each command type is an input counted in SDRAM clocks. The refresh period is also an input. The power-up interval is a parameter, so a simulation can shorten it. A sticky `ready` output tells the host that bring-up is complete. A sticky `refresh_overrun` output reports that a refresh period expired while the previous request was still waiting. The geometry assumed is 4 banks, a 13-bit row address and a 9-bit column address.

Top module: `sdr_bringup_seq`

## Requirements
- R1: While `rst_n` is low, `sd_cke` is 0, the command pins {cs_n,ras_n,cas_n,we_n} read NOP = 4'b0111, `ready` is 0 and `refresh_overrun` is 0.
- R2: `sd_cke` goes high at the first rising clock edge after reset release and then stays high. No command other than NOP is issued before PRECHARGE ALL. PRECHARGE ALL is command 4'b0010 with `sd_addr` = 13'h0400 (A10 set) and `sd_ba` = 0. It appears exactly PWRUP_CLKS cycles after `sd_cke` rises.
- R3: Exactly INIT_REFRESHES (default 8) AUTO REFRESH commands (4'b0001) follow PRECHARGE ALL. The first comes `cfg_rp_gap` cycles after the precharge. Each later one comes `cfg_rfc_gap` cycles after the previous refresh.
- R4: LOAD MODE (4'b0000) is issued `cfg_rfc_gap` cycles after the last init refresh. It drives `sd_ba` = 0 and `sd_addr` = {3'b0, cfg_single_wr, 2'b00, cfg_cas_lat[2:0], cfg_interleave, cfg_burst_code[2:0]}. With burst code 0, sequential bursts, CAS latency 3 and single-location writes, this word is 13'h0230. Load mode is issued once only.
- R5: A gap input of 0 behaves as a gap of 1 cycle.
- R6: `ready` rises exactly `cfg_mrd_gap` cycles after LOAD MODE. No command is issued in that window. `ready` then stays high until reset.
- R7: When `cfg_refi` is at least every gap input, the first periodic AUTO REFRESH appears `cfg_refi`+1 cycles after LOAD MODE. Each later one follows the previous one by exactly `cfg_refi` cycles.
- R8: A refresh request that is still waiting for the auto-refresh gap is served as soon as that gap ends. A second interval expiry while a request is still pending sets `refresh_overrun`, which stays high until reset. The flag stays 0 when `cfg_refi` is not less than `cfg_rfc_gap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SDRAM clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rp_gap | input | 4 | Cycles from PRECHARGE ALL to the next command |
| cfg_rfc_gap | input | 4 | Cycles from AUTO REFRESH to the next command |
| cfg_mrd_gap | input | 4 | Cycles from LOAD MODE to the next command or to ready |
| cfg_refi | input | 16 | Refresh interval in clocks |
| cfg_burst_code | input | 3 | Burst length code for the mode word |
| cfg_interleave | input | 1 | Burst type: 1 interleaved, 0 sequential |
| cfg_cas_lat | input | 3 | CAS latency for the mode word |
| cfg_single_wr | input | 1 | 1 selects single-location write bursts |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |
| ready | output | 1 | Bring-up complete, memory usable |
| refresh_overrun | output | 1 | Sticky missed-refresh flag |

## Verification
The sequence is exercised under several timing and mode patterns:
- The nominal timing with the 761-clock interval and the default mode word checks the exact cycle of every bring-up command. It also checks the 13'h0230 word.
- All-zero gaps separate a "treat 0 as 1" design from one that underflows its gap counter.
- An interval shorter than the refresh gap makes requests pile up. This distinguishes correct waiting and overrun flagging from dropped or early refreshes.
- Randomly drawn gaps, intervals and mode fields catch swapped gap inputs and misplaced mode-word fields that fixed values could hide.

// File: rtl/sdr_seq_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes a command word ordered {cs_n, ras_n, cas_n, we_n}.
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_LMR  = 4'b0000,
        CMD_AREF = 4'b0001,
        CMD_PRE  = 4'b0010,
        CMD_NOP  = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_PRE,
        ST_AREF,
        ST_LMR,
        ST_RUN
    } seq_state_e;

    localparam int unsigned ALL_BANK_BIT = 10;

    // Pack mode-register fields into the address word (upper bits zero).
    function automatic logic [15:0] pack_mode(input logic [2:0] burst_code,
                                              input logic       interleave,
                                              input logic [2:0] cas_lat,
                                              input logic       single_wr);
        logic [15:0] w;
        w        = '0;
        w[2:0]   = burst_code;
        w[3]     = interleave;
        w[6:4]   = cas_lat;
        w[9]     = single_wr;
        return w;
    endfunction

    // Reload value for a minimum-gap counter; a gap of 0 acts as 1.
    function automatic logic [3:0] gap_reload(input logic [3:0] gap);
        return (gap == 4'd0) ? 4'd0 : gap - 4'd1;
    endfunction

endpackage

// File: rtl/sdr_gap_timer.sv
// Down-counter that enforces the minimum spacing after a command.
// Assumes: load has priority; idle is high when the count has reached zero.
module sdr_gap_timer #(
    parameter int unsigned WAIT_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    output logic              idle
);
    logic [WAIT_W-1:0] cnt_q;

    // Load a fresh wait or count the current one down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign idle = (cnt_q == '0);
endmodule

// File: rtl/sdr_refi_timer.sv
// Refresh interval timer: after start it expires every 'interval' cycles,
// reloading itself, and keeps a pending request until it is served.
// Assumes: an interval of 0 acts as 1; overrun is sticky until reset.
module sdr_refi_timer #(
    parameter int unsigned REFI_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REFI_W-1:0] interval,
    input  logic              service,
    output logic              pending,
    output logic              overrun
);
    logic              run_q;
    logic [REFI_W-1:0] cnt_q;
    logic [REFI_W-1:0] reload;
    logic              expire;

    assign reload = (interval == '0) ? '0 : interval - 1'b1;
    assign expire = run_q && (cnt_q == '0);

    // Interval counter with reload on every expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (start) begin
            run_q <= 1'b1;
            cnt_q <= reload;
        end else if (expire) begin
            cnt_q <= reload;
        end else if (run_q) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Pending request and sticky overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
            overrun <= 1'b0;
        end else begin
            pending <= (pending && !service) || expire;
            if (expire && pending && !service)
                overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/sdr_cmd_drive.sv
// Registered SDRAM pin driver: turns a command code plus address into
// the pin levels on the next edge. CKE is set once and held.
module sdr_cmd_drive #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cke_set,
    input  sdr_seq_pkg::sdr_cmd_e   cmd_in,
    input  logic [ROW_W-1:0]        addr_in,
    output logic                    sd_cke,
    output logic                    sd_cs_n,
    output logic                    sd_ras_n,
    output logic                    sd_cas_n,
    output logic                    sd_we_n,
    output logic [BANK_W-1:0]       sd_ba,
    output logic [ROW_W-1:0]        sd_addr
);
    import sdr_seq_pkg::*;

    sdr_cmd_e cmd_q;

    // Register command, address and clock enable onto the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sd_cke  <= 1'b0;
            cmd_q   <= CMD_NOP;
            sd_addr <= '0;
        end else begin
            sd_cke  <= sd_cke | cke_set;
            cmd_q   <= cmd_in;
            sd_addr <= addr_in;
        end
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
    assign sd_ba = '0;
endmodule

// File: rtl/sdr_bringup_seq.sv
// SDRAM power-up and refresh command sequencer (top).
// Runs: CKE high, power-up wait, PRECHARGE ALL, INIT_REFRESHES x
// AUTO REFRESH, LOAD MODE, then periodic refresh from an interval timer.
// Assumes: configuration inputs are stable from reset release onward;
// ROW_W >= 11 so that A10 and the mode word fit.
module sdr_bringup_seq #(
    parameter int unsigned PWRUP_CLKS     = 1000000,
    parameter int unsigned INIT_REFRESHES = 8,
    parameter int unsigned ROW_W          = 13,
    parameter int unsigned BANK_W         = 2,
    parameter int unsigned GAP_W          = 4,
    parameter int unsigned REFI_W         = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAP_W-1:0]  cfg_rp_gap,
    input  logic [GAP_W-1:0]  cfg_rfc_gap,
    input  logic [GAP_W-1:0]  cfg_mrd_gap,
    input  logic [REFI_W-1:0] cfg_refi,
    input  logic [2:0]        cfg_burst_code,
    input  logic              cfg_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_single_wr,
    output logic              sd_cke,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic              ready,
    output logic              refresh_overrun
);
    import sdr_seq_pkg::*;

    localparam int unsigned PW_W   = $clog2(PWRUP_CLKS + 1);
    localparam int unsigned WAIT_W = (PW_W > GAP_W) ? PW_W : GAP_W;
    localparam int unsigned RC_W   = $clog2(INIT_REFRESHES + 1);
    localparam logic [WAIT_W-1:0] PWRUP_RELOAD = WAIT_W'(PWRUP_CLKS - 1);

    seq_state_e        state_q;
    logic [RC_W-1:0]   refs_left_q;
    logic              ready_q;

    sdr_cmd_e          cmd_d;
    logic [ROW_W-1:0]  addr_d;
    logic              cke_set;
    logic              gap_load;
    logic [WAIT_W-1:0] gap_val;
    logic              gap_idle;
    logic              refi_start;
    logic              refi_service;
    logic              refi_pending;
    logic [15:0]       mode_word;
    logic [ROW_W-1:0]  pre_all_addr;

    assign mode_word    = pack_mode(cfg_burst_code, cfg_interleave, cfg_cas_lat, cfg_single_wr);
    assign pre_all_addr = ROW_W'(1) << ALL_BANK_BIT;

    // Choose the command for this cycle and the wait that follows it.
    always_comb begin
        cmd_d        = CMD_NOP;
        addr_d       = '0;
        cke_set      = 1'b0;
        gap_load     = 1'b0;
        gap_val      = '0;
        refi_start   = 1'b0;
        refi_service = 1'b0;
        case (state_q)
            ST_PWRUP: begin
                cke_set  = 1'b1;
                gap_load = 1'b1;
                gap_val  = PWRUP_RELOAD;
            end
            ST_PRE: if (gap_idle) begin
                cmd_d    = CMD_PRE;
                addr_d   = pre_all_addr;
                gap_load = 1'b1;
                gap_val  = WAIT_W'(gap_reload(cfg_rp_gap));
            end
            ST_AREF: if (gap_idle) begin
                cmd_d    = CMD_AREF;
                gap_load = 1'b1;
                gap_val  = WAIT_W'(gap_reload(cfg_rfc_gap));
            end
            ST_LMR: if (gap_idle) begin
                cmd_d      = CMD_LMR;
                addr_d     = mode_word[ROW_W-1:0];
                gap_load   = 1'b1;
                gap_val    = WAIT_W'(gap_reload(cfg_mrd_gap));
                refi_start = 1'b1;
            end
            ST_RUN: if (gap_idle && refi_pending) begin
                cmd_d        = CMD_AREF;
                gap_load     = 1'b1;
                gap_val      = WAIT_W'(gap_reload(cfg_rfc_gap));
                refi_service = 1'b1;
            end
            default: cmd_d = CMD_NOP;
        endcase
    end

    // Advance the bring-up script and count the init refreshes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_PWRUP;
            refs_left_q <= '0;
        end else begin
            case (state_q)
                ST_PWRUP: state_q <= ST_PRE;
                ST_PRE: if (gap_idle) begin
                    state_q     <= ST_AREF;
                    refs_left_q <= RC_W'(INIT_REFRESHES);
                end
                ST_AREF: if (gap_idle) begin
                    refs_left_q <= refs_left_q - 1'b1;
                    if (refs_left_q == RC_W'(1))
                        state_q <= ST_LMR;
                end
                ST_LMR: if (gap_idle) state_q <= ST_RUN;
                default: state_q <= state_q;
            endcase
        end
    end

    // Sticky ready once the load-mode gap has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_q <= 1'b0;
        else if (state_q == ST_RUN && gap_idle)
            ready_q <= 1'b1;
    end

    assign ready = ready_q;

    sdr_gap_timer #(.WAIT_W(WAIT_W)) i_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .idle     (gap_idle)
    );

    sdr_refi_timer #(.REFI_W(REFI_W)) i_refi (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (refi_start),
        .interval (cfg_refi),
        .service  (refi_service),
        .pending  (refi_pending),
        .overrun  (refresh_overrun)
    );

    sdr_cmd_drive #(.ROW_W(ROW_W), .BANK_W(BANK_W)) i_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .cke_set  (cke_set),
        .cmd_in   (cmd_d),
        .addr_in  (addr_d),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr)
    );
endmodule

// File: rtl/sdr_bringup_chk.sv
// Protocol checker for the bring-up sequencer, bound to the top module.
// Tracks the last command and the cycles since it, and checks spacing,
// pin encodings and sticky flags at the ports.
module sdr_bringup_chk #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned BANK_W = 2,
    parameter int unsigned GAP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [GAP_W-1:0]  cfg_rp_gap,
    input logic [GAP_W-1:0]  cfg_rfc_gap,
    input logic [GAP_W-1:0]  cfg_mrd_gap,
    input logic [2:0]        cfg_burst_code,
    input logic              cfg_interleave,
    input logic [2:0]        cfg_cas_lat,
    input logic              cfg_single_wr,
    input logic              sd_cke,
    input logic              sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BANK_W-1:0] sd_ba,
    input logic [ROW_W-1:0]  sd_addr,
    input logic              ready,
    input logic              refresh_overrun
);
    import sdr_seq_pkg::*;

    localparam int unsigned SW = GAP_W + 1;

    logic [3:0]    cmd;
    logic          is_cmd;
    logic [3:0]    last_q;
    logic [SW-1:0] since_q;
    logic [SW-1:0] rp_min, rfc_min, mrd_min;
    logic [ROW_W-1:0] exp_mode;

    assign cmd     = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    assign is_cmd  = (cmd != CMD_NOP);
    assign rp_min  = (cfg_rp_gap  == '0) ? SW'(1) : SW'(cfg_rp_gap);
    assign rfc_min = (cfg_rfc_gap == '0) ? SW'(1) : SW'(cfg_rfc_gap);
    assign mrd_min = (cfg_mrd_gap == '0) ? SW'(1) : SW'(cfg_mrd_gap);
    assign exp_mode = ROW_W'({cfg_single_wr, 2'b00, cfg_cas_lat, cfg_interleave, cfg_burst_code});

    // Remember the last command seen and the cycles since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= CMD_NOP;
            since_q <= '1;
        end else if (is_cmd) begin
            last_q  <= cmd;
            since_q <= SW'(1);
        end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_CMD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        is_cmd |-> sd_cke);                                                   // R2
    AST_PRE_ALL_BANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PRE) |-> (sd_addr == (ROW_W'(1) << ALL_BANK_BIT) && sd_ba == '0)); // R2
    AST_MODE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LMR) |-> (sd_addr == exp_mode && sd_ba == '0 && !ready)); // R4
    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_q == CMD_PRE) |-> (since_q >= rp_min));               // R3
    AST_AREF_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_q == CMD_AREF) |-> (since_q >= rfc_min));             // R8
    AST_LMR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (is_cmd && last_q == CMD_LMR) |-> (since_q >= mrd_min));              // R6
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);                                                     // R6
    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_overrun |=> refresh_overrun);                                 // R8
    AST_CKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);                                                   // R2
endmodule

bind sdr_bringup_seq sdr_bringup_chk #(
    .ROW_W(ROW_W), .BANK_W(BANK_W), .GAP_W(GAP_W)
) i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_rp_gap      (cfg_rp_gap),
    .cfg_rfc_gap     (cfg_rfc_gap),
    .cfg_mrd_gap     (cfg_mrd_gap),
    .cfg_burst_code  (cfg_burst_code),
    .cfg_interleave  (cfg_interleave),
    .cfg_cas_lat     (cfg_cas_lat),
    .cfg_single_wr   (cfg_single_wr),
    .sd_cke          (sd_cke),
    .sd_cs_n         (sd_cs_n),
    .sd_ras_n        (sd_ras_n),
    .sd_cas_n        (sd_cas_n),
    .sd_we_n         (sd_we_n),
    .sd_ba           (sd_ba),
    .sd_addr         (sd_addr),
    .ready           (ready),
    .refresh_overrun (refresh_overrun)
);

// File: tb/test_sdr_bringup_seq.sv
// Bench: directed cases (nominal, zero gaps, overrun) plus seeded random
// configurations; every command is logged with its cycle and compared
// against spacing and encodings computed here from the requirements.
module test_sdr_bringup_seq;
    localparam int PW   = 20;
    localparam int NREF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_rp_gap = 4'd2, cfg_rfc_gap = 4'd6, cfg_mrd_gap = 4'd2;
    logic [15:0] cfg_refi = 16'd761;
    logic [2:0]  cfg_burst_code = 3'd0, cfg_cas_lat = 3'd3;
    logic        cfg_interleave = 1'b0, cfg_single_wr = 1'b1;
    logic        sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, ready, refresh_overrun;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;

    sdr_bringup_seq #(.PWRUP_CLKS(PW), .INIT_REFRESHES(NREF)) i_sdr_bringup_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_rp_gap(cfg_rp_gap), .cfg_rfc_gap(cfg_rfc_gap), .cfg_mrd_gap(cfg_mrd_gap),
        .cfg_refi(cfg_refi), .cfg_burst_code(cfg_burst_code), .cfg_interleave(cfg_interleave),
        .cfg_cas_lat(cfg_cas_lat), .cfg_single_wr(cfg_single_wr),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .ready(ready), .refresh_overrun(refresh_overrun)
    );

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cyc = 0;
    int ev_n, cke_cyc, rdy_cyc;
    int ev_cyc [64];
    logic [3:0]  ev_cmd [64];
    logic [12:0] ev_addr [64];
    logic [1:0]  ev_ba [64];
    bit logging = 1'b0;
    logic [3:0] pins;

    assign pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always @(posedge clk) cyc <= cyc + 1;

    // Command log, sampled on the falling edge.
    always @(negedge clk) begin
        if (logging) begin
            if (sd_cke && cke_cyc < 0) cke_cyc = cyc;
            if (ready && rdy_cyc < 0) rdy_cyc = cyc;
            if (pins != 4'b0111 && ev_n < 64) begin
                ev_cyc[ev_n]  = cyc;
                ev_cmd[ev_n]  = pins;
                ev_addr[ev_n] = sd_addr;
                ev_ba[ev_n]   = sd_ba;
                ev_n = ev_n + 1;
            end
        end
    end

    function automatic int eff(input int g);
        return (g == 0) ? 1 : g;
    endfunction

    function automatic int exp_mode(input int bl, input int il, input int cas, input int sw);
        return (sw << 9) | (cas << 4) | (il << 3) | bl;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_case(input int rp, input int rfc, input int mrd, input int refi,
                            input int bl, input int il, input int cas, input int sw,
                            input int nper, input bit exp_ovr);
        int rel, t_lmr, wait_lim;
        cfg_rp_gap = 4'(rp); cfg_rfc_gap = 4'(rfc); cfg_mrd_gap = 4'(mrd);
        cfg_refi = 16'(refi); cfg_burst_code = 3'(bl); cfg_interleave = 1'(il);
        cfg_cas_lat = 3'(cas); cfg_single_wr = 1'(sw);
        logging = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(sd_cke == 1'b0, "R1 cke", int'(sd_cke), 0);
        chk(pins == 4'b0111, "R1 nop", int'(pins), 7);
        chk(ready == 1'b0, "R1 ready", int'(ready), 0);
        chk(refresh_overrun == 1'b0, "R1 overrun", int'(refresh_overrun), 0);
        ev_n = 0; cke_cyc = -1; rdy_cyc = -1;
        rel = cyc;
        logging = 1'b1;
        rst_n = 1'b1;
        wait_lim = 0;
        while (ev_n < 2 + NREF + nper && wait_lim < 20000) begin
            @(negedge clk);
            wait_lim++;
        end
        if (exp_ovr) repeat (40) @(negedge clk);
        chk(ev_n >= 2 + NREF + nper, "R3 command count", ev_n, 2 + NREF + nper);
        if (ev_n < 2 + NREF + nper) return;
        // R2: CKE then PRECHARGE ALL
        chk(cke_cyc == rel + 1, "R2 cke rise", cke_cyc, rel + 1);
        chk(ev_cmd[0] == 4'b0010, "R2 precharge cmd", int'(ev_cmd[0]), 2);
        chk(ev_addr[0] == 13'h0400 && ev_ba[0] == 2'd0, "R2 precharge addr", int'(ev_addr[0]), 'h400);
        chk(ev_cyc[0] == cke_cyc + PW, "R2 power-up wait", ev_cyc[0] - cke_cyc, PW);
        // R3 / R5: init refresh group and spacing
        for (int i = 1; i <= NREF; i++) begin
            chk(ev_cmd[i] == 4'b0001, "R3 init refresh cmd", int'(ev_cmd[i]), 1);
            chk(ev_cyc[i] - ev_cyc[i-1] == ((i == 1) ? eff(rp) : eff(rfc)),
                "R3 R5 init spacing", ev_cyc[i] - ev_cyc[i-1], (i == 1) ? eff(rp) : eff(rfc));
        end
        // R4: mode load
        t_lmr = ev_cyc[NREF+1];
        chk(ev_cmd[NREF+1] == 4'b0000, "R4 load mode cmd", int'(ev_cmd[NREF+1]), 0);
        chk(t_lmr - ev_cyc[NREF] == eff(rfc), "R4 load mode spacing", t_lmr - ev_cyc[NREF], eff(rfc));
        chk(int'(ev_addr[NREF+1]) == exp_mode(bl, il, cas, sw) && ev_ba[NREF+1] == 2'd0,
            "R4 mode word", int'(ev_addr[NREF+1]), exp_mode(bl, il, cas, sw));
        // R6: ready timing
        chk(rdy_cyc == t_lmr + eff(mrd), "R6 ready rise", rdy_cyc - t_lmr, eff(mrd));
        chk(ev_cyc[NREF+2] - t_lmr >= eff(mrd), "R6 quiet after load", ev_cyc[NREF+2] - t_lmr, eff(mrd));
        // R7: periodic refresh
        chk(ev_cyc[NREF+2] - t_lmr == refi + 1, "R7 first periodic", ev_cyc[NREF+2] - t_lmr, refi + 1);
        for (int j = NREF + 2; j < ev_n; j++) begin
            chk(ev_cmd[j] == 4'b0001, "R4 R7 only refresh after init", int'(ev_cmd[j]), 1);
            if (j > NREF + 2)
                chk(ev_cyc[j] - ev_cyc[j-1] == (exp_ovr ? eff(rfc) : refi),
                    exp_ovr ? "R8 backlog spacing" : "R7 periodic spacing",
                    ev_cyc[j] - ev_cyc[j-1], exp_ovr ? eff(rfc) : refi);
        end
        // R8: overrun flag
        chk(refresh_overrun == exp_ovr, "R8 overrun flag", int'(refresh_overrun), int'(exp_ovr));
        chk(ready == 1'b1, "R6 ready held", int'(ready), 1);
    endtask

    initial begin
        int s;
        s = $urandom(32'h5D7A1);
        // Nominal timing and default mode word (0x230).
        run_case(2, 6, 2, 761, 0, 0, 3, 1, 2, 1'b0);
        // Zero gaps behave as one cycle.
        run_case(0, 0, 0, 16, 3, 1, 2, 0, 3, 1'b0);
        // Interval shorter than the refresh gap forces overrun.
        run_case(1, 8, 2, 3, 1, 0, 3, 1, 4, 1'b1);
        // Seeded random configurations.
        for (int k = 0; k < 6; k++) begin
            run_case(int'($urandom_range(1, 15)), int'($urandom_range(1, 15)),
                     int'($urandom_range(1, 15)), int'($urandom_range(16, 60)),
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 1)),
                     int'($urandom_range(2, 3)), int'($urandom_range(0, 1)), 3, 1'b0);
        end
        // Final reset check after a run.
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sd_cke == 1'b0 && ready == 1'b0, "R1 final reset", int'(ready), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule